// File: doc/BRIEF.md
# Detect-and-skip subranging SAR controller

This block is the digital sequencer of a two-stage successive-approximation converter. A sample strobe starts a conversion. The input is held on two capacitor arrays at once: a small coarse array and a full-resolution fine array. The controller first runs a 7-bit search on the coarse array, one comparator decision per cycle. It drives each coarse capacitor from the common-mode level to either the reference or ground. When that search ends, it flags coarse completion. It then programs the seven upper capacitors of the fine array in a single step, directly from the coarse code, instead of searching them again.

When programming those seven capacitors, every capacitor whose controlling coarse bit disagrees with the coarse sign bit stays at common mode (skipped). This produces the same residue as switching all of them, with less charge moved. After one settling cycle the controller resolves the five low bits on the fine array. It then presents a 12-bit offset-binary result with an end-of-conversion pulse. Every capacitor control is a 2-bit level code for the positive array. The negative array always receives the mirrored code. A skip mask reports which fine upper capacitors were left parked, for use by later digital correction.

Top module: `subrange_sar_ctrl`

## Requirements
- R1: While reset is asserted every capacitor code is common mode (2'b00), `coarse_done_o` and `eoc_o` are low, and `result_o` and `skip_mask_o` are zero.
- R2: A strobe seen in idle starts a conversion. All codes stay common mode through the sampling cycle. Coarse bits are decided MSB first, one per clock, the first at the second rising edge after the accepting edge. A decided bit of 1 drives that coarse capacitor's positive code to ground (2'b10), and a 0 drives it to reference (2'b01).
- R3: `coarse_done_o` is a one-cycle pulse, high in the cycle after the last coarse decision (the eighth cycle after the accepting edge).
- R4: Skip mask bit i (i >= 1) is set exactly when coarse bit i-1 differs from the coarse MSB. Mask bit 0 is never set. The mask updates at the edge that ends the `coarse_done_o` cycle and holds until the next conversion reaches that point.
- R5: At that same edge the fine upper capacitors are loaded. Each capacitor that is not skipped goes to ground when the coarse MSB is 1 and to reference when it is 0. Skipped capacitors stay at common mode. The lowest fine upper capacitor (index 0) is always switched.
- R6: One settling cycle follows the fine upper load. The five fine low bits are then decided MSB first, one per clock, with a 1 driving that capacitor's code to ground and a 0 to reference.
- R7: `eoc_o` is a one-cycle pulse 15 cycles after the accepting edge. `result_o` then holds the coarse bits above the fine bits. For an ideal comparator this equals the input as offset binary (input code plus 2048, MSB set for non-negative input), and the value is held until the next pulse.
- R8: Every negative-array code is the positive one with ground and reference swapped; common mode stays common mode.
- R9: The redundant calibration capacitor code is common mode on both arrays at all times.
- R10: A strobe arriving while a conversion is in progress is ignored. A strobe present in the `eoc_o` cycle starts the next conversion.
- R11: From the `eoc_o` cycle until the next decision, all coarse and fine codes are common mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sample_i | input | 1 | Sample strobe starting a conversion |
| cmp_coarse_i | input | 1 | Coarse comparator decision (1: positive residue) |
| cmp_fine_i | input | 1 | Fine comparator decision (1: positive residue) |
| coarse_p_o | output | 14 | Coarse positive-array codes, 2 bits per capacitor |
| coarse_n_o | output | 14 | Coarse negative-array codes |
| fmsb_p_o | output | 14 | Fine upper-capacitor positive codes |
| fmsb_n_o | output | 14 | Fine upper-capacitor negative codes |
| flsb_p_o | output | 10 | Fine low-capacitor positive codes |
| flsb_n_o | output | 10 | Fine low-capacitor negative codes |
| spare_p_o | output | 2 | Redundant capacitor positive code |
| spare_n_o | output | 2 | Redundant capacitor negative code |
| coarse_done_o | output | 1 | Coarse search finished pulse |
| skip_mask_o | output | 7 | Fine upper capacitors left at common mode |
| eoc_o | output | 1 | End-of-conversion pulse |
| result_o | output | 12 | Conversion result |

## Verification
The bench builds the controller with its default 7 coarse and 5 fine bits. It closes the loop through an ideal residue model of both arrays, so every one of the 4096 output codes can be reached. The chosen inputs cover both full-scale ends, the zero crossing, and small inputs where almost every fine upper capacitor is skipped. A pseudo-random sweep covers mixed skip patterns. Held and mid-conversion strobes exercise the ignore rule and the back-to-back restart from the end-of-conversion cycle.

// File: rtl/subrange_sar_pkg.sv
package subrange_sar_pkg;

    typedef enum logic [1:0] {
        CAP_CM  = 2'b00,
        CAP_REF = 2'b01,
        CAP_GND = 2'b10
    } cap_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_COARSE,
        ST_XFER,
        ST_SETTLE,
        ST_FINE
    } seq_state_e;

    // A decided 1 pulls the positive top plate down: bottom plate to ground.
    function automatic logic [1:0] drive_for(input logic bit_hi);
        return bit_hi ? CAP_GND : CAP_REF;
    endfunction

    function automatic logic [1:0] mirror_code(input logic [1:0] c);
        case (c)
            CAP_GND: return CAP_REF;
            CAP_REF: return CAP_GND;
            default: return CAP_CM;
        endcase
    endfunction

endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import subrange_sar_pkg::*;
#(
    parameter int CBITS = 7,
    parameter int FBITS = 5,
    localparam int MAXB = (CBITS > FBITS) ? CBITS : FBITS,
    localparam int IDXW = (MAXB > 1) ? $clog2(MAXB) : 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            sample_i,
    output logic            start_o,
    output logic            coarse_step_o,
    output logic            fine_step_o,
    output logic            xfer_o,
    output logic            park_o,
    output logic [IDXW-1:0] idx_o,
    output logic            coarse_done_o,
    output logic            eoc_o
);

    typedef struct packed {
        seq_state_e      state;
        logic [IDXW-1:0] idx;
        logic            cdone;
        logic            eoc;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d         = seq_q;
        seq_d.cdone   = 1'b0;
        seq_d.eoc     = 1'b0;
        start_o       = 1'b0;
        coarse_step_o = 1'b0;
        fine_step_o   = 1'b0;
        xfer_o        = 1'b0;
        park_o        = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (sample_i) begin
                    start_o     = 1'b1;
                    seq_d.state = ST_SAMPLE;
                end
            end
            ST_SAMPLE: begin
                seq_d.state = ST_COARSE;
                seq_d.idx   = IDXW'(CBITS - 1);
            end
            ST_COARSE: begin
                coarse_step_o = 1'b1;
                if (seq_q.idx == '0) begin
                    seq_d.state = ST_XFER;
                    seq_d.cdone = 1'b1;
                end else begin
                    seq_d.idx = seq_q.idx - IDXW'(1);
                end
            end
            ST_XFER: begin
                xfer_o      = 1'b1;
                seq_d.state = ST_SETTLE;
            end
            ST_SETTLE: begin
                seq_d.state = ST_FINE;
                seq_d.idx   = IDXW'(FBITS - 1);
            end
            ST_FINE: begin
                fine_step_o = 1'b1;
                if (seq_q.idx == '0) begin
                    park_o      = 1'b1;
                    seq_d.state = ST_IDLE;
                    seq_d.eoc   = 1'b1;
                end else begin
                    seq_d.idx = seq_q.idx - IDXW'(1);
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q.state <= ST_IDLE;
            seq_q.idx   <= '0;
            seq_q.cdone <= 1'b0;
            seq_q.eoc   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign idx_o         = seq_q.idx;
    assign coarse_done_o = seq_q.cdone;
    assign eoc_o         = seq_q.eoc;

    assert_cdone_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        coarse_done_o |=> !coarse_done_o)
        else $error("coarse done wider than one cycle");

    assert_eoc_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eoc_o |=> !eoc_o)
        else $error("end of conversion wider than one cycle");

    // R10: once busy, the sequencer never re-enters the sampling phase directly
    assert_busy_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.state != ST_IDLE) |=> (seq_q.state != ST_SAMPLE))
        else $error("strobe restarted a running conversion");

endmodule

// File: rtl/sar_cap_bank.sv
module sar_cap_bank
    import subrange_sar_pkg::*;
#(
    parameter int BITS = 7,
    parameter int IDXW = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic            park_i,
    input  logic            step_i,
    input  logic [IDXW-1:0] idx_i,
    input  logic            dec_i,
    // bit vector including the decision taken in this cycle
    output logic [BITS-1:0] bits_o,
    output logic [2*BITS-1:0] ctl_o
);

    typedef struct packed {
        logic [BITS-1:0]   bits;
        logic [2*BITS-1:0] ctl;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (start_i) begin
            bank_d.bits = '0;
            bank_d.ctl  = '0;
        end else if (step_i) begin
            for (int b = 0; b < BITS; b++) begin
                if (idx_i == IDXW'(b)) begin
                    bank_d.bits[b]         = dec_i;
                    bank_d.ctl[2*b +: 2]   = drive_for(dec_i);
                end
            end
        end
        if (park_i) begin
            bank_d.ctl = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bits_o = bank_d.bits;
    assign ctl_o  = bank_q.ctl;

endmodule

// File: rtl/skip_decoder.sv
module skip_decoder
    import subrange_sar_pkg::*;
#(
    parameter int BITS = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              park_i,
    input  logic [BITS-1:0]   code_i,
    output logic [2*BITS-1:0] ctl_o,
    output logic [BITS-1:0]   mask_o
);

    typedef struct packed {
        logic [2*BITS-1:0] ctl;
        logic [BITS-1:0]   mask;
    } dec_t;

    dec_t dec_d, dec_q;

    logic [BITS-1:0]   sw;
    logic [2*BITS-1:0] dec_ctl;

    for (genvar i = 0; i < BITS; i++) begin : g_cap
        if (i == 0) begin : g_last
            assign sw[i] = 1'b1;
        end else begin : g_upper
            assign sw[i] = (code_i[i-1] == code_i[BITS-1]);
        end
        assign dec_ctl[2*i +: 2] = sw[i] ? drive_for(code_i[BITS-1]) : 2'(CAP_CM);
    end

    always_comb begin
        dec_d = dec_q;
        if (load_i) begin
            dec_d.ctl  = dec_ctl;
            dec_d.mask = ~sw;
        end
        if (park_i) begin
            dec_d.ctl = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign ctl_o  = dec_q.ctl;
    assign mask_o = dec_q.mask;

    for (genvar i = 0; i < BITS; i++) begin : g_chk
        assert_skip_parked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(load_i) && mask_o[i]) |-> (ctl_o[2*i +: 2] == CAP_CM))
            else $error("skipped capacitor was switched");
    end

    assert_lowest_switched_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(load_i) |-> (ctl_o[1:0] != CAP_CM && !mask_o[0]))
        else $error("lowest upper capacitor not switched");

endmodule

// File: rtl/cap_mirror.sv
module cap_mirror
    import subrange_sar_pkg::*;
#(
    parameter int N = 7
) (
    input  logic [2*N-1:0] pos_i,
    output logic [2*N-1:0] neg_o
);

    for (genvar i = 0; i < N; i++) begin : g_flip
        assign neg_o[2*i +: 2] = mirror_code(pos_i[2*i +: 2]);
    end

endmodule

// File: rtl/subrange_sar_ctrl.sv
module subrange_sar_ctrl
    import subrange_sar_pkg::*;
#(
    parameter int COARSE_BITS = 7,
    parameter int FINE_BITS   = 5,
    localparam int RES_W = COARSE_BITS + FINE_BITS,
    localparam int MAXB  = (COARSE_BITS > FINE_BITS) ? COARSE_BITS : FINE_BITS,
    localparam int IDXW  = (MAXB > 1) ? $clog2(MAXB) : 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     sample_i,
    input  logic                     cmp_coarse_i,
    input  logic                     cmp_fine_i,
    output logic [2*COARSE_BITS-1:0] coarse_p_o,
    output logic [2*COARSE_BITS-1:0] coarse_n_o,
    output logic [2*COARSE_BITS-1:0] fmsb_p_o,
    output logic [2*COARSE_BITS-1:0] fmsb_n_o,
    output logic [2*FINE_BITS-1:0]   flsb_p_o,
    output logic [2*FINE_BITS-1:0]   flsb_n_o,
    output logic [1:0]               spare_p_o,
    output logic [1:0]               spare_n_o,
    output logic                     coarse_done_o,
    output logic [COARSE_BITS-1:0]   skip_mask_o,
    output logic                     eoc_o,
    output logic [RES_W-1:0]         result_o
);

    logic            start, c_step, f_step, xfer, park;
    logic [IDXW-1:0] idx;
    logic [COARSE_BITS-1:0] c_bits;
    logic [FINE_BITS-1:0]   f_bits;
    logic [RES_W-1:0]       result_d, result_q;

    sar_sequencer #(.CBITS(COARSE_BITS), .FBITS(FINE_BITS)) u_seq (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .sample_i      (sample_i),
        .start_o       (start),
        .coarse_step_o (c_step),
        .fine_step_o   (f_step),
        .xfer_o        (xfer),
        .park_o        (park),
        .idx_o         (idx),
        .coarse_done_o (coarse_done_o),
        .eoc_o         (eoc_o)
    );

    sar_cap_bank #(.BITS(COARSE_BITS), .IDXW(IDXW)) u_coarse (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start),
        .park_i  (park),
        .step_i  (c_step),
        .idx_i   (idx),
        .dec_i   (cmp_coarse_i),
        .bits_o  (c_bits),
        .ctl_o   (coarse_p_o)
    );

    sar_cap_bank #(.BITS(FINE_BITS), .IDXW(IDXW)) u_fine_lsb (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start),
        .park_i  (park),
        .step_i  (f_step),
        .idx_i   (idx),
        .dec_i   (cmp_fine_i),
        .bits_o  (f_bits),
        .ctl_o   (flsb_p_o)
    );

    skip_decoder #(.BITS(COARSE_BITS)) u_skip (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (xfer),
        .park_i (park),
        .code_i (c_bits),
        .ctl_o  (fmsb_p_o),
        .mask_o (skip_mask_o)
    );

    cap_mirror #(.N(COARSE_BITS)) u_mir_c (.pos_i(coarse_p_o), .neg_o(coarse_n_o));
    cap_mirror #(.N(COARSE_BITS)) u_mir_m (.pos_i(fmsb_p_o),   .neg_o(fmsb_n_o));
    cap_mirror #(.N(FINE_BITS))   u_mir_l (.pos_i(flsb_p_o),   .neg_o(flsb_n_o));

    // redundant calibration capacitor is parked throughout conversion
    assign spare_p_o = CAP_CM;
    assign spare_n_o = CAP_CM;

    always_comb begin
        result_d = result_q;
        if (park) begin
            result_d = {c_bits, f_bits};
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            result_q <= '0;
        end else begin
            result_q <= result_d;
        end
    end

    assign result_o = result_q;

    // R6: settling cycle, then first fine cycle still with low capacitors parked
    assert_settle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        coarse_done_o |=> ##1 (flsb_p_o == '0 && fmsb_p_o[1:0] != CAP_CM))
        else $error("fine low search started without settling");

    assert_eoc_parked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eoc_o |-> (coarse_p_o == '0 && fmsb_p_o == '0 && flsb_p_o == '0))
        else $error("capacitors not parked at end of conversion");

endmodule

// File: tb/subrange_sar_ctrl_bench.sv
module subrange_sar_ctrl_bench;
    import subrange_sar_pkg::*;

    localparam int CB = 7;
    localparam int FB = 5;
    localparam int RW = CB + FB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample = 1'b0;
    logic cmp_c, cmp_f;
    logic [2*CB-1:0] coarse_p, coarse_n, fmsb_p, fmsb_n;
    logic [2*FB-1:0] flsb_p, flsb_n;
    logic [1:0] spare_p, spare_n;
    logic coarse_done, eoc;
    logic [CB-1:0] skip_mask;
    logic [RW-1:0] result;

    int x_live = 0;
    int checks = 0;
    int errors = 0;
    int eoc_cnt = 0;
    bit chk_en = 1'b0;

    always #5 clk = ~clk;

    subrange_sar_ctrl u_subrange_sar_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .sample_i(sample),
        .cmp_coarse_i(cmp_c), .cmp_fine_i(cmp_f),
        .coarse_p_o(coarse_p), .coarse_n_o(coarse_n),
        .fmsb_p_o(fmsb_p), .fmsb_n_o(fmsb_n),
        .flsb_p_o(flsb_p), .flsb_n_o(flsb_n),
        .spare_p_o(spare_p), .spare_n_o(spare_n),
        .coarse_done_o(coarse_done), .skip_mask_o(skip_mask),
        .eoc_o(eoc), .result_o(result)
    );

    function automatic int sgn(input logic [1:0] c);
        if (c == 2'b10) return 1;
        if (c == 2'b01) return -1;
        return 0;
    endfunction

    // ideal analog residue, doubled units so residues are odd and never zero
    always_comb begin
        int rc;
        int rf;
        rc = 2 * x_live + 1;
        rf = 2 * x_live + 1;
        for (int k = 0; k < CB; k++) begin
            rc = rc - sgn(coarse_p[2*k +: 2]) * (1 << (k + 5));
            rf = rf - sgn(fmsb_p[2*k +: 2]) * (1 << (k + 5));
        end
        for (int j = 0; j < FB; j++) rf = rf - sgn(flsb_p[2*j +: 2]) * (1 << j);
        rf = rf - sgn(spare_p) * 32;
        cmp_c = (rc > 0);
        cmp_f = (rf > 0);
    end

    // behavioural reference: phase counter since the accepting edge
    bit busy = 1'b0;
    int ph = -1;
    logic [RW-1:0] e = '0;
    logic [RW-1:0] res_exp = '0;
    logic [CB-1:0] mask_exp = '0;

    function automatic logic [CB-1:0] exp_mask(input logic [RW-1:0] c);
        logic [CB-1:0] m;
        m = '0;
        for (int i = 1; i < CB; i++) m[i] = (c[i+4] != c[RW-1]);
        return m;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            busy = 1'b0; ph = -1; res_exp = '0; mask_exp = '0;
        end else if (busy) begin
            ph = ph + 1;
            if (ph == 9) mask_exp = exp_mask(e);
            if (ph == 15) begin busy = 1'b0; res_exp = e; end
        end else if (sample) begin
            busy = 1'b1; ph = 0; e = RW'(x_live + 2048);
        end else begin
            ph = -1;
        end
    end

    function automatic logic [1:0] flip(input logic [1:0] c);
        if (c == 2'b10) return 2'b01;
        if (c == 2'b01) return 2'b10;
        return c;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic string tg(input string t);
        if (!rst_n) return "R1";
        if (!busy) return "R11";
        return t;
    endfunction

    always @(negedge clk) begin
        if (eoc === 1'b1) eoc_cnt++;
        if (chk_en) begin
            logic [2*CB-1:0] ec, em, nc, nm;
            logic [2*FB-1:0] el, nl;
            string rt;
            ec = '0; em = '0; el = '0;
            for (int k = 0; k < CB; k++)
                if (busy && ph >= 8 - k) ec[2*k +: 2] = e[k+5] ? 2'b10 : 2'b01;
            if (busy && ph >= 9)
                for (int i = 0; i < CB; i++)
                    if (i == 0 || e[i+4] == e[RW-1]) em[2*i +: 2] = e[RW-1] ? 2'b10 : 2'b01;
            for (int j = 0; j < FB; j++)
                if (busy && ph >= 15 - j) el[2*j +: 2] = e[j] ? 2'b10 : 2'b01;
            for (int k = 0; k < CB; k++) begin
                nc[2*k +: 2] = flip(coarse_p[2*k +: 2]);
                nm[2*k +: 2] = flip(fmsb_p[2*k +: 2]);
            end
            for (int j = 0; j < FB; j++) nl[2*j +: 2] = flip(flsb_p[2*j +: 2]);
            rt = rst_n ? "R7" : "R1";
            chk(coarse_p === ec, tg("R2"), "coarse codes", 32'(coarse_p), 32'(ec));
            chk(fmsb_p === em, tg("R5"), "fine upper codes", 32'(fmsb_p), 32'(em));
            chk(flsb_p === el, tg("R6"), "fine low codes", 32'(flsb_p), 32'(el));
            chk(coarse_n === nc && fmsb_n === nm && flsb_n === nl, "R8", "negative mirror",
                32'(coarse_n), 32'(nc));
            chk(spare_p === 2'b00 && spare_n === 2'b00, "R9", "spare codes",
                32'({spare_p, spare_n}), 32'(0));
            chk(coarse_done === (busy && ph == 8), rst_n ? "R3" : "R1", "coarse done",
                32'(coarse_done), 32'(busy && ph == 8));
            chk(eoc === (!busy && ph == 15), rt, "eoc", 32'(eoc), 32'(!busy && ph == 15));
            chk(result === res_exp, rt, "result", 32'(result), 32'(res_exp));
            chk(skip_mask === mask_exp, rst_n ? "R4" : "R1", "skip mask",
                32'(skip_mask), 32'(mask_exp));
        end
    end

    task automatic convert(input int xv);
        @(negedge clk);
        x_live = xv;
        sample = 1'b1;
        @(negedge clk);
        sample = 1'b0;
        repeat (16) @(negedge clk);
    endtask

    initial begin
        int base;
        logic [31:0] seed;
        @(posedge clk);
        @(negedge clk);
        chk_en = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R7 extremes and zero crossing; R4/R5 small inputs skip most capacitors
        convert(0);
        convert(-1);
        convert(2047);
        convert(-2048);
        convert(5);
        convert(-6);
        convert(1000);
        convert(-1500);
        convert(31);
        convert(-32);
        seed = 32'h1234_5678;
        for (int n = 0; n < 30; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            convert(int'(seed[27:16]) - 2048);
        end
        // R10: strobe in the middle of a conversion is ignored
        @(negedge clk);
        base = eoc_cnt;
        x_live = 700;
        sample = 1'b1;
        @(negedge clk);
        sample = 1'b0;
        repeat (4) @(negedge clk);
        sample = 1'b1;
        @(negedge clk);
        sample = 1'b0;
        repeat (20) @(negedge clk);
        chk(eoc_cnt - base == 1, "R10", "conversions after mid strobe",
            32'(eoc_cnt - base), 32'(1));
        // R10: strobe held high restarts from the end-of-conversion cycle
        base = eoc_cnt;
        x_live = -300;
        sample = 1'b1;
        repeat (34) @(negedge clk);
        sample = 1'b0;
        repeat (20) @(negedge clk);
        chk(eoc_cnt - base == 3, "R10", "back-to-back conversions",
            32'(eoc_cnt - base), 32'(3));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule